// File: doc/BRIEF.md
# Pipelined Byte-Writable Synchronous SRAM Core

This block holds the storage array and the data path of a synchronous static RAM with a registered read pipeline and two byte lanes. An external burst sequencer registers the address and classifies each cycle. It presents to this block the word address, a select flag that says whether the chip enables were active, and a flag that marks a processor-strobe start edge. Alongside these come an active-low global write enable, an active-low byte-write enable, one active-low strobe per lane, and an active-low output enable.

A read cycle loads the addressed word into an output register on the sampling edge. A write cycle captures the data bus and the lane mask into an input register on the sampling edge, and the array is updated on the following edge. Reads forward any pending lanes, so a read placed right after a write returns the new data. The bidirectional pin bus is split into `din_i`, `dout_o` and a drive flag `dout_en_o`.

The default depth is 256 words so that the model stays small when elaborated. Setting `ADDR_W = 17` gives the full 128K-word array. `DATA_W` selects 18-bit words with 9-bit lanes, or 16-bit words with 8-bit lanes.

Top module: `sram_pipe_top`

## Requirements
- R1: On a read cycle sampled at edge E, `dout_o` holds the addressed word from just after E until the next read cycle. A read cycle is one where `sel_i` is 1, no lane is written and no byte strobe is seen.
- R2: `dout_en_o` is 1 only while `oe_ni` is 0 and the most recently sampled cycle was a selected read cycle. A deselected cycle (`sel_i` = 0) leaves `dout_en_o` at 0 for the cycle that follows.
- R3: When `gwe_ni` is 0 on a selected edge with `proc_strobe_i` = 0, both lanes are written. This happens whatever values `bwe_ni` and `bw_ni` carry.
- R4: When `gwe_ni` is 1, lane l is written only if both `bwe_ni` and `bw_ni[l]` are 0. A strobe with `bwe_ni` = 1 leaves the stored word unchanged.
- R5: On an edge with `proc_strobe_i` = 1, every write input is ignored and the cycle is a read.
- R6: When any `bw_ni` bit is 0 on a selected edge with `proc_strobe_i` = 0, `dout_en_o` is 0 for the following cycle, even with `oe_ni` = 0.
- R7: A read of an address on the cycle right after a write to it returns the newly written lanes.
- R8: Lane 0 (`bw_ni[0]`) covers data bits [LANE_W-1:0] and lane 1 covers the bits above them, where LANE_W = DATA_W/2. With the default DATA_W = 18 this gives bits [8:0] and [17:9].
- R9: After reset, `dout_o` is 0 and `dout_en_o` is 0.
- R10: With `sel_i` = 0, nothing is written, whatever the write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all sampling on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip enables active for this cycle |
| proc_strobe_i | input | 1 | This edge starts a cycle through the processor strobe |
| addr_i | input | ADDR_W | Word address from the sequencer |
| gwe_ni | input | 1 | Global write enable, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bw_ni | input | LANES | Per-lane write strobes, active low |
| oe_ni | input | 1 | Output enable, active low (asynchronous gate) |
| din_i | input | DATA_W | Write data from the bus |
| dout_o | output | DATA_W | Registered read data |
| dout_en_o | output | 1 | Drive enable for the bus |

## Verification
Read data and the drive decision are both registered on the sampling edge, so their effect is due one edge after the stimulus. `oe_ni` gates the drive flag combinationally within the same cycle. Array writes land one edge after capture, and that delay is visible at the ports only through forwarding. The bench therefore sets the inputs on the falling edge and compares both outputs 1 ns after the next rising edge. It uses a model whose array changes at once. Every cycle is compared, including non-read cycles, where `dout_o` must hold its previous value.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
  function automatic int lane_width(input int data_w, input int lanes);
    return data_w / lanes;
  endfunction
endpackage

// File: rtl/sram_wr_stage.sv
module sram_wr_stage #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              proc_strobe_i,
  input  logic              gwe_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              rd_cyc_o,
  output logic [LANES-1:0]  wr_mask_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic             wr_ok;
  logic             strobe_seen;
  logic [LANES-1:0] lane_we;

  // processor-strobe edge: all write controls masked
  assign wr_ok       = sel_i & ~proc_strobe_i;
  assign strobe_seen = wr_ok & ~(&bw_ni);

  for (genvar l = 0; l < LANES; l++) begin : g_lane_we
    assign lane_we[l] = wr_ok & (~gwe_ni | (~bwe_ni & ~bw_ni[l]));
  end

  assign rd_cyc_o = sel_i & ~(|lane_we) & ~strobe_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_mask_o <= '0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_mask_o <= lane_we;
      if (|lane_we) begin
        wr_addr_o <= addr_i;
        wr_data_o <= din_i;
      end
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  wr_mask_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int LANE_W = sram_pipe_pkg::lane_width(DATA_W, LANES);
  localparam int DEPTH  = 1 << ADDR_W;

  logic addr_hit;
  assign addr_hit = (wr_addr_i == rd_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk_i) begin
      if (wr_mask_i[l]) mem[wr_addr_i] <= wr_data_i[l*LANE_W +: LANE_W];
    end

    // pending lane forwarded so back-to-back RAW sees new data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q <= '0;
      end else if (rd_en_i) begin
        lane_q <= (wr_mask_i[l] && addr_hit) ? wr_data_i[l*LANE_W +: LANE_W]
                                             : mem[rd_addr_i];
      end
    end

    assign rd_data_o[l*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/sram_out_ctl.sv
module sram_out_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_cyc_i,
  input  logic oe_ni,
  output logic dout_en_o
);
  logic rd_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_act_q <= 1'b0;
    else         rd_act_q <= rd_cyc_i;
  end

  assign dout_en_o = rd_act_q & ~oe_ni;
endmodule

// File: rtl/sram_pipe_top.sv
module sram_pipe_top #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              proc_strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              gwe_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o
);
  logic              rd_cyc;
  logic [LANES-1:0]  wr_mask_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  sram_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) i_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_i        (sel_i),
    .proc_strobe_i(proc_strobe_i),
    .gwe_ni       (gwe_ni),
    .bwe_ni       (bwe_ni),
    .bw_ni        (bw_ni),
    .addr_i       (addr_i),
    .din_i        (din_i),
    .rd_cyc_o     (rd_cyc),
    .wr_mask_o    (wr_mask_q),
    .wr_addr_o    (wr_addr_q),
    .wr_data_o    (wr_data_q)
  );

  sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) i_arr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_mask_i(wr_mask_q),
    .wr_addr_i(wr_addr_q),
    .wr_data_i(wr_data_q),
    .rd_en_i  (rd_cyc),
    .rd_addr_i(addr_i),
    .rd_data_o(dout_o)
  );

  sram_out_ctl i_oc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_cyc_i (rd_cyc),
    .oe_ni    (oe_ni),
    .dout_en_o(dout_en_o)
  );
endmodule

// File: rtl/sram_pipe_chk.sv
module sram_pipe_chk #(
  parameter int LANES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             proc_strobe_i,
  input logic             gwe_ni,
  input logic             bwe_ni,
  input logic [LANES-1:0] bw_ni,
  input logic             oe_ni,
  input logic             dout_en_o,
  input logic [LANES-1:0] wr_mask_i
);
  assert_en_needs_oe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> !oe_ni);

  assert_desel_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sel_i) |-> !dout_en_o);

  assert_gwe_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !proc_strobe_i && !gwe_ni) |=> (&wr_mask_i));

  assert_byte_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !proc_strobe_i && gwe_ni && bwe_ni) |=> (wr_mask_i == '0));

  assert_proc_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && proc_strobe_i) |=> (wr_mask_i == '0));

  assert_strobe_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !proc_strobe_i && !(&bw_ni)) |=> !dout_en_o);

  assert_desel_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (wr_mask_i == '0));
endmodule

bind sram_pipe_top sram_pipe_chk #(.LANES(LANES)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_i        (sel_i),
  .proc_strobe_i(proc_strobe_i),
  .gwe_ni       (gwe_ni),
  .bwe_ni       (bwe_ni),
  .bw_ni        (bw_ni),
  .oe_ni        (oe_ni),
  .dout_en_o    (dout_en_o),
  .wr_mask_i    (wr_mask_q)
);

// File: tb/test_sram_pipe_top.sv
module test_sram_pipe_top;
  localparam int AW = 8;
  localparam int DW = 18;
  localparam int LW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, proc = 1'b0, gwe_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1;
  logic [1:0]    bw_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] ref_mem [1<<AW];
  logic [DW-1:0] exp_dout = '0;

  always #2 clk = ~clk;

  sram_pipe_top #(.ADDR_W(AW), .DATA_W(DW), .LANES(2)) i_sram_pipe_top (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .proc_strobe_i(proc),
    .addr_i(addr), .gwe_ni(gwe_n), .bwe_ni(bwe_n), .bw_ni(bw_n),
    .oe_ni(oe_n), .din_i(din), .dout_o(dout), .dout_en_o(dout_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] lane_mask(input logic s, p, g, b, input logic [1:0] w);
    logic [1:0] m;
    for (int l = 0; l < 2; l++) m[l] = s && !p && (!g || (!b && !w[l]));
    return m;
  endfunction

  task automatic step(input logic s, p, g, b, input logic [1:0] w, input logic o,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    logic [1:0] m;
    logic strobe, rd, exp_en;
    @(negedge clk);
    sel = s; proc = p; gwe_n = g; bwe_n = b; bw_n = w; oe_n = o; addr = a; din = d;
    m      = lane_mask(s, p, g, b, w);
    strobe = s && !p && (w != 2'b11);
    rd     = s && (m == 2'b00) && !strobe;
    if (rd) exp_dout = ref_mem[a];
    for (int l = 0; l < 2; l++)
      if (m[l]) ref_mem[a][l*LW +: LW] = d[l*LW +: LW];
    exp_en = rd && !o;
    @(posedge clk); #1;
    check({req, " dout"}, 32'(dout), 32'(exp_dout));
    check({req, " dout_en"}, 32'(dout_en), 32'(exp_en));
  endtask

  task automatic rd_word(input logic [AW-1:0] a, input string req);
    step(1, 0, 1, 1, 2'b11, 0, a, '0, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1;
    check("R9 dout", 32'(dout), 32'h0);
    check("R9 dout_en", 32'(dout_en), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R3: fill via global write, random strobes ignored
    for (int a = 0; a < (1 << AW); a++)
      step(1, 0, 0, $urandom_range(0, 1), 2'($urandom), 1, AW'(a), DW'(a * 1031 + 5), "R3");
    for (int i = 0; i < 16; i++) rd_word(AW'(i * 17), "R1");

    // R7: write then immediate read
    step(1, 0, 0, 1, 2'b11, 1, 8'h21, 18'h2A5A5, "R7");
    rd_word(8'h21, "R7");
    // R8: lane 0 = low bits
    step(1, 0, 1, 0, 2'b10, 1, 8'h22, 18'h3FFFF, "R8");
    rd_word(8'h22, "R8");
    step(1, 0, 1, 0, 2'b01, 1, 8'h22, 18'h00000, "R4");
    rd_word(8'h22, "R4");
    // back-to-back lane writes then read
    step(1, 0, 1, 0, 2'b10, 1, 8'h26, 18'h12345, "R7");
    step(1, 0, 1, 0, 2'b01, 1, 8'h26, 18'h2BCDE, "R7");
    rd_word(8'h26, "R7");
    // R6/R4: strobe low, bwe high: no write, drive off despite oe low
    step(1, 0, 1, 1, 2'b00, 0, 8'h23, 18'h15555, "R6");
    rd_word(8'h23, "R4");
    // R5: processor strobe edge ignores write controls
    step(1, 1, 0, 0, 2'b00, 0, 8'h24, 18'h0F0F0, "R5");
    rd_word(8'h24, "R5");
    // R10: deselected write
    step(0, 0, 0, 0, 2'b00, 0, 8'h25, 18'h3C3C3, "R10");
    rd_word(8'h25, "R10");
    // R2: oe high on a read
    step(1, 0, 1, 1, 2'b11, 1, 8'h25, '0, "R2");
    step(0, 0, 1, 1, 2'b11, 0, 8'h25, '0, "R2");

    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 9) != 0, $urandom_range(0, 4) == 0,
           $urandom_range(0, 3) != 0, $urandom_range(0, 1), 2'($urandom),
           $urandom_range(0, 1), AW'($urandom_range(0, 7)), DW'($urandom), "R1");

    finish_run();
  end
endmodule